// File: doc/BRIEF.md
# Dual-Mode Watchdog / Interval Timer

An 8-bit up-counter driven by a selectable power-of-two prescaler of the system clock. When the counter wraps from its maximum value back to zero, the action depends on one mode bit. In interval mode a sticky overflow flag is set and an interrupt request is raised for the processor. In watchdog mode a single-cycle pulse is driven on an external overflow output, and the flag is left untouched.

Software reaches the block through a small register bus with two locations. Address 0 is the control/status byte, which holds the flag, the mode, the enable bit and the clock-select field. Address 1 is the counter itself, which can be both read and written. The flag follows a read-then-clear protocol. A write of 0 to the flag bit clears it only after a control/status read has returned the flag as 1. A write that turns the timer off in interval mode also clears the flag.

Top module: `wdog_itimer`

## Requirements
- R1: The counter is 8 bits wide, counts upward and wraps from 0xFF to 0x00. It is read at bus address 1 (`bus_addr`=1).
- R2: While the enable bit (control/status bit 5) is 0, the counter and prescaler are held at zero, and a write to the counter has no effect: address 1 reads 0x00.
- R3: The clock-select field (control/status bits 2:0) sets the counter period. Codes 0..7 select divide-by 2, 64, 128, 256, 512, 1024, 4096 and 8192. The prescaler restarts from zero when the timer is enabled.
- R4: In interval mode (bit 6 = 0), a wrap sets the flag (bit 7) in the cycle after the wrapping edge, and `irq_o` equals flag AND interval mode.
- R5: In watchdog mode (bit 6 = 1), a wrap produces exactly one high cycle on `wd_ovf_o` and does not set the flag.
- R6: Writing 1 to bit 7 never changes the flag. Writing 0 to bit 7 clears the flag only if a control/status read has returned bit 7 = 1 since the flag was last cleared.
- R7: In interval mode, a control/status write with bit 5 = 0 clears the flag.
- R8: When a wrap and a clearing write fall in the same cycle, the flag stays set.
- R9: A counter write while enabled takes priority over an increment in the same cycle.
- R10: Control/status layout: bit 7 is the flag, bit 6 the mode, bit 5 the enable, bits 4:3 always read 0, and bits 2:0 are the clock select. All bits reset to 0. `bus_rdata` is 0 unless `bus_sel` and `bus_rd` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0: control/status, 1: counter |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq_o | output | 1 | Interval interrupt request |
| wd_ovf_o | output | 1 | Watchdog overflow pulse |

## Verification
Register writes take effect at the first clock edge under the strobe. Read data is combinational and is valid within the same cycle as the strobe. A wrap shows on the flag, `irq_o` and `wd_ovf_o` one cycle after the edge at which the counter passes 0xFF, which is the same cycle in which the counter reads 0x00. The reference model advances at each rising edge from the inputs that were driven at the preceding falling edge. It is compared with the outputs 1 ns after that edge, so every result is checked in the cycle in which it is due. The simultaneous wrap-and-clear case is set up by waiting for the model to predict a wrap at the next edge, and then issuing the clearing write in that same cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int REG_W    = 8;
   localparam int NTAP     = 8;
   localparam int SEL_W    = 3;
   localparam int FLAG_BIT = 7;
   localparam int MODE_BIT = 6;
   localparam int EN_BIT   = 5;

   typedef enum logic {
      MODE_INTERVAL = 1'b0,
      MODE_WATCHDOG = 1'b1
   } wdt_mode_e;

   // log2 of the division ratio per clock-select code
   function automatic int tap_log(input int idx);
      case (idx)
         0:       return 1;
         1:       return 6;
         2:       return 7;
         3:       return 8;
         4:       return 9;
         5:       return 10;
         6:       return 12;
         default: return 13;
      endcase
   endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
   import wdt_pkg::*;
#(
   parameter int PRE_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   logic [PRE_W-1:0] pre_q;
   logic [NTAP-1:0]  taps;

   initial begin
      assert (tap_log(NTAP-1) <= PRE_W)
         else $error("prescaler width too small for the slowest tap");
      assert (NTAP == (1 << SEL_W))
         else $error("tap count must match select width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (!run_i) pre_q <= '0;
      else             pre_q <= pre_q + 1'b1;
   end

   for (genvar g = 0; g < NTAP; g++) begin : g_tap
      localparam int L = tap_log(g);
      assign taps[g] = &pre_q[L-1:0];
   end

   assign tick_o = run_i & taps[sel_i];

   // R3: the prescaler is back at zero after a disabled cycle
   p_pre_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> pre_q == '0);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 8)
         else $error("counter width must be 2..8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (ld_i)   cnt_q <= ld_val_i;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
   end

   assign wrap_o = run_i & ~ld_i & tick_i & (&cnt_q);
   assign cnt_o  = cnt_q;

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> cnt_q == '0);
   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> cnt_q == '0);
   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && ld_i) |=> cnt_q == $past(ld_val_i));
endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
   import wdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             rd_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic             wrap_i,
   output logic             flag_o,
   output wdt_mode_e        mode_o,
   output logic             en_o,
   output logic [SEL_W-1:0] sel_o,
   output logic             pulse_o
);
   logic             flag_q, armed_q, en_q, pulse_q;
   wdt_mode_e        mode_q;
   logic [SEL_W-1:0] sel_q;
   logic             set_c, clr_c, flag_d, armed_d;
   logic             unused_bits;

   assign unused_bits = ^wdata_i[4:3];

   assign set_c   = wrap_i & (mode_q == MODE_INTERVAL);
   assign clr_c   = wr_i & ((~wdata_i[FLAG_BIT] & armed_q) |
                            ((mode_q == MODE_INTERVAL) & ~wdata_i[EN_BIT]));
   assign flag_d  = set_c | (flag_q & ~clr_c);
   assign armed_d = flag_d & (armed_q | (rd_i & flag_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
         mode_q  <= MODE_INTERVAL;
         en_q    <= 1'b0;
         sel_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         flag_q  <= flag_d;
         armed_q <= armed_d;
         pulse_q <= wrap_i & (mode_q == MODE_WATCHDOG);
         if (wr_i) begin
            mode_q <= wdt_mode_e'(wdata_i[MODE_BIT]);
            en_q   <= wdata_i[EN_BIT];
            sel_q  <= wdata_i[SEL_W-1:0];
         end
      end
   end

   assign flag_o  = flag_q;
   assign mode_o  = mode_q;
   assign en_o    = en_q;
   assign sel_o   = sel_q;
   assign pulse_o = pulse_q;

   p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && mode_q == MODE_INTERVAL) |=> flag_q);
   p_wd_noflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && mode_q == MODE_WATCHDOG && !flag_q && !wr_i) |=> !flag_q);
   p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
   p_clear_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(wr_i));
   p_set_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(wrap_i));
   p_overflow_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && mode_q == MODE_INTERVAL && wr_i) |=> flag_q);
endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer
   import wdt_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int PRE_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic             bus_addr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   output logic             irq_o,
   output logic             wd_ovf_o
);
   logic             csr_wr, csr_rd, cnt_wr, tick, wrap, flag, en;
   wdt_mode_e        mode;
   logic [SEL_W-1:0] sel;
   logic [CNT_W-1:0] cnt;
   logic [REG_W-1:0] csr_byte;

   initial begin
      assert (CNT_W <= REG_W) else $error("counter wider than bus");
   end

   assign csr_wr = bus_sel & bus_wr & ~bus_addr;
   assign csr_rd = bus_sel & bus_rd & ~bus_addr;
   assign cnt_wr = bus_sel & bus_wr &  bus_addr;

   wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run_i(en), .sel_i(sel), .tick_o(tick));

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run_i(en), .tick_i(tick), .ld_i(cnt_wr),
      .ld_val_i(bus_wdata[CNT_W-1:0]), .cnt_o(cnt), .wrap_o(wrap));

   wdt_csr u_csr (
      .clk(clk), .rst_n(rst_n), .wr_i(csr_wr), .rd_i(csr_rd),
      .wdata_i(bus_wdata), .wrap_i(wrap), .flag_o(flag), .mode_o(mode),
      .en_o(en), .sel_o(sel), .pulse_o(wd_ovf_o));

   always_comb begin
      csr_byte           = '0;
      csr_byte[FLAG_BIT] = flag;
      csr_byte[MODE_BIT] = mode;
      csr_byte[EN_BIT]   = en;
      csr_byte[SEL_W-1:0] = sel;
   end

   always_comb begin
      if (bus_sel && bus_rd) bus_rdata = bus_addr ? REG_W'(cnt) : csr_byte;
      else                   bus_rdata = '0;
   end

   assign irq_o = flag & (mode == MODE_INTERVAL);

   p_irq_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_WATCHDOG) |-> !irq_o);
   p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_rd) |-> bus_rdata == '0);
endmodule

// File: tb/wdog_itimer_test.sv
`timescale 1ns/1ps
module wdog_itimer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_o, wd_ovf_o;

   int checks = 0;
   int errors = 0;
   int wd_pulses = 0;
   int irq_seen = 0;

   // behavioural reference state
   int  m_cnt = 0, m_pre = 0, m_cks = 0;
   bit  m_flag = 0, m_mode = 0, m_en = 0, m_armed = 0, m_pulse = 0;

   always #2.5 clk = ~clk;

   wdog_itimer uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o), .wd_ovf_o(wd_ovf_o));

   function automatic int div_of(input int code);
      int t[8] = '{2, 64, 128, 256, 512, 1024, 4096, 8192};
      return t[code];
   endfunction

   function automatic bit tick_next();
      return m_en && ((m_pre % div_of(m_cks)) == div_of(m_cks) - 1);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // model step and per-cycle comparison
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_cks = 0; m_flag = 0; m_mode = 0;
         m_en = 0; m_armed = 0; m_pulse = 0;
      end else begin
         bit tk, ovf, cw, kw, cr, clr, nflag;
         tk  = tick_next();
         cw  = bus_sel && bus_wr && !bus_addr;
         kw  = bus_sel && bus_wr && bus_addr;
         cr  = bus_sel && bus_rd && !bus_addr;
         ovf = m_en && !kw && tk && (m_cnt == 255);
         clr = cw && ((!bus_wdata[7] && m_armed) || (!m_mode && !bus_wdata[5]));
         nflag = (ovf && !m_mode) ? 1'b1 : (clr ? 1'b0 : m_flag);
         m_armed = nflag ? (m_armed || (cr && m_flag)) : 1'b0;
         m_pulse = ovf && m_mode;
         if (!m_en)   m_cnt = 0;
         else if (kw) m_cnt = bus_wdata;
         else if (tk) m_cnt = (m_cnt + 1) % 256;
         m_pre = m_en ? (m_pre + 1) % 8192 : 0;
         m_flag = nflag;
         if (cw) begin
            m_mode = bus_wdata[6]; m_en = bus_wdata[5]; m_cks = bus_wdata[2:0];
         end
         #1;
         begin
            int exp_rd;
            exp_rd = 0;
            if (bus_sel && bus_rd)
               exp_rd = bus_addr ? m_cnt : ((m_flag << 7) | (m_mode << 6) | (m_en << 5) | m_cks);
            check(irq_o === (m_flag && !m_mode), "R4 irq", irq_o, m_flag && !m_mode);
            check(wd_ovf_o === m_pulse, "R5 wd_ovf", wd_ovf_o, m_pulse);
            check(bus_rdata === 8'(exp_rd), bus_addr ? "R1 rdata" : "R10 rdata",
                  bus_rdata, exp_rd);
            if (wd_ovf_o) wd_pulses++;
            if (irq_o) irq_seen++;
         end
      end
   end

   task automatic wr(input bit a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input bit a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      idle(3);
      rst_n = 1;
      idle(2);
      // R10 reset state
      rd(0, d); check(d == 8'h00, "R10 reset csr", d, 8'h00);
      rd(1, d); check(d == 8'h00, "R1 reset cnt", d, 8'h00);
      // R2 counter write ignored while disabled
      wr(1, 8'h55); rd(1, d); check(d == 8'h00, "R2 write ignored", d, 8'h00);
      // R10 reserved bits read 0
      wr(0, 8'h1F); rd(0, d); check(d == 8'h07, "R10 reserved bits", d, 8'h07);
      // R4 interval overflow at divide-by-2
      wr(0, 8'h20); wr(1, 8'hF0); idle(40);
      check(irq_o == 1, "R4 irq after wrap", irq_o, 1);
      // R6 clear without prior read has no effect, write 1 has no effect
      wr(0, 8'h20); check(irq_o == 1, "R6 clear without read", irq_o, 1);
      wr(0, 8'hA0); check(irq_o == 1, "R6 write one", irq_o, 1);
      rd(0, d); check(d[7] == 1, "R6 flag reads 1", d[7], 1);
      wr(0, 8'h20); check(irq_o == 0, "R6 clear after read", irq_o, 0);
      // R9 counter load while running
      wr(1, 8'h80); rd(1, d);
      check(d == 8'h80 || d == 8'h81, "R9 load priority", d, 8'h80);
      // R3 divide-by-64 timing
      wr(0, 8'h00); wr(0, 8'h21); wr(1, 8'hFF); idle(55);
      check(irq_o == 0, "R3 div64 early", irq_o, 0);
      idle(15);
      check(irq_o == 1, "R3 div64 due", irq_o, 1);
      // R7 disable in interval mode clears flag
      wr(0, 8'h01); check(irq_o == 0, "R7 disable clears", irq_o, 0);
      rd(1, d); check(d == 8'h00, "R2 held at zero", d, 8'h00);
      // R3 divide-by-256 timing
      wr(0, 8'h23); wr(1, 8'hFF); idle(240);
      check(irq_o == 0, "R3 div256 early", irq_o, 0);
      idle(30);
      check(irq_o == 1, "R3 div256 due", irq_o, 1);
      wr(0, 8'h03);
      // R5 watchdog mode pulse
      wr(0, 8'h60); wd_pulses = 0; irq_seen = 0; wr(1, 8'hFE); idle(20);
      check(wd_pulses == 1, "R5 one pulse", wd_pulses, 1);
      check(irq_seen == 0, "R5 no irq", irq_seen, 0);
      rd(0, d); check(d[7] == 0, "R5 flag untouched", d[7], 0);
      // R8 overflow and clear in the same cycle
      wr(0, 8'h00); wr(0, 8'h20); wr(1, 8'hF0); idle(40);
      rd(0, d); check(d[7] == 1, "R8 flag armed", d[7], 1);
      wr(1, 8'hFF);
      begin
         int guard;
         guard = 0;
         @(negedge clk);
         while (!(m_cnt == 255 && tick_next()) && guard < 20) begin
            @(negedge clk); guard++;
         end
      end
      bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h20;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      check(irq_o == 1, "R8 overflow wins", irq_o, 1);
      idle(2);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule